// File: doc/BRIEF.md
# I2C Master Start Control with Arbitration-Loss Interrupt

This block is the control and status core of an I2C bus master. Software writes a small register port to enable the interface, give a slave address byte and ask for master mode. If the bus is idle, the block drives a START condition. It then shifts the address byte out MSB first and releases SDA for the acknowledge clock. At the end of that ninth clock it raises an event flag, holds SCL low and interrupts. Clearing the event flag ends the transfer with a STOP and drops master mode.

A bus monitor tracks START and STOP conditions from any master and keeps a bus-busy status. It also counts SCL clocks from the last START. A master request made while the bus is busy counts as lost arbitration. The same holds for a request made in the very cycle a START is seen. In that case the block never touches SDA, leaves master mode off and sets a lost flag. It then waits for the ninth clock of the other master's transfer. There it raises the event flag and stretches SCL low. The interrupt for this lost-transfer event is gated by a separate lost-interrupt enable and by the lost flag. SCL is held low only while the event flag is set. SCL and SDA are open-drain: an `*_oe` output of 1 pulls the line low.

Top module: `i2c_al_master`

Register map, selected by `wr_sel` / `rd_sel`:
- 0, control: bit 0 = enable, bit 1 = master request (reads 1 while in master mode), bit 2 = lost-interrupt enable.
- 1, status: bit 0 = lost flag, bit 1 = event flag, bit 2 = bus busy (read only).
- 2, the address byte to send.

## Requirements
- R1: After reset, all three registers read 0, `scl_oe` and `sda_oe` are 0 and `irq` is 0.
- R2: Bus busy (status bit 2) becomes 1 after SDA falls while SCL is high. It becomes 0 after SDA rises while SCL is high. Both apply whoever drives the condition.
- R3: With enable already 1 and the bus idle, a control write with bits 0 and 1 set makes master mode read 1. On the next clock, SDA is pulled low while SCL stays high (a START).
- R4: The address byte (register 2) goes out MSB first, one bit per SCL high period, with SDA released for a 1. During the ninth SCL high period `sda_oe` is 0.
- R5: A request made while bus busy is 1, or in the same cycle a START is detected, sets the lost flag (status bit 0). Master mode reads 0 afterwards and `sda_oe` stays 0 for the rest of that transfer.
- R6: The event flag (status bit 1) is 0 before the ninth SCL clock after a START. It is set once SCL falls at the end of that ninth clock, for an own transfer and for a pending lost transfer.
- R7: While the event flag is 1, SCL is held low. Writing 0 to status bit 1 releases SCL. After an own transfer it also generates a STOP, so bus busy and master mode return to 0.
- R8: An own-transfer event drives `irq` to 1. A lost-transfer event drives `irq` to (lost-interrupt enable AND lost flag). `irq` is 0 before the ninth clock.
- R9: Writing 0 to status bit 0 clears the lost flag and drops its interrupt while the event flag stays 1. Writing 1 to status bits 0 or 1 changes nothing.
- R10: Writing 0 to control bit 2 stops a pending lost-transfer interrupt, and writing 1 brings it back.
- R11: Writing 0 to control bit 0 clears the lost flag, event flag, bus busy and master mode, releases both lines and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register selected for reading |
| rd_data | output | 8 | Read data (combinational) |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
A software master request and the monitor's detection of a foreign START can land in the same clock. In that clock, bus busy is still 0. The bench provokes this by letting SDA fall with SCL high on the same falling clock edge at which it presents the control write. It expects the request to be judged lost: lost flag 1, master mode 0 and SDA never pulled. A second overlap is tested in the same way: a status write that clears the lost flag while the event flag must survive. There the bench checks that SCL stays low and that the interrupt drops.

// File: rtl/i2c_alm_pkg.sv
package i2c_alm_pkg;

  typedef enum logic [2:0] {
    MS_IDLE, MS_START, MS_LOW, MS_HIGH, MS_HOLD, MS_STOP_LO, MS_STOP_HI
  } ms_state_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_MST  = 1;
  localparam int CTRL_LIE  = 2;
  localparam int STAT_LOST = 0;
  localparam int STAT_EVT  = 1;
  localparam int STAT_BUSY = 2;

  // SDA falling while SCL stays high
  function automatic logic start_cond(logic scl, logic scl_q, logic sda, logic sda_q);
    return scl & scl_q & sda_q & ~sda;
  endfunction

  // SDA rising while SCL stays high
  function automatic logic stop_cond(logic scl, logic scl_q, logic sda, logic sda_q);
    return scl & scl_q & ~sda_q & sda;
  endfunction

  // A request loses when the bus is owned or being claimed right now
  function automatic logic request_lost(logic busy, logic start_seen);
    return busy | start_seen;
  endfunction

  // Lost-transfer events are gated by enable and flag; own events always interrupt
  function automatic logic irq_level(logic evt, logic from_loss, logic lost, logic lie);
    return evt & (from_loss ? (lost & lie) : 1'b1);
  endfunction

endpackage

// File: rtl/i2c_alm_busmon.sv
module i2c_alm_busmon
  import i2c_alm_pkg::*;
#(
  parameter int CLKS_PER_XFER = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_det,
  output logic stop_det,
  output logic ninth_fall,
  output logic busy
);
  localparam int CW = $clog2(CLKS_PER_XFER + 1);

  logic          scl_q, sda_q;
  logic [CW-1:0] clk_cnt;
  logic          scl_rise, scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_det  = en & start_cond(scl_i, scl_q, sda_i, sda_q);
  assign stop_det   = en & stop_cond(scl_i, scl_q, sda_i, sda_q);
  assign scl_rise   = scl_i & ~scl_q;
  assign scl_fall   = ~scl_i & scl_q;
  assign ninth_fall = en & busy & scl_fall & (clk_cnt == CW'(CLKS_PER_XFER));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      clk_cnt <= '0;
    end else if (!en) begin
      busy    <= 1'b0;
      clk_cnt <= '0;
    end else begin
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
      if (start_det || stop_det || ninth_fall) clk_cnt <= '0;
      else if (scl_rise && clk_cnt != CW'(CLKS_PER_XFER)) clk_cnt <= clk_cnt + 1'b1;
    end
  end

  assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy);
  assert_idle_on_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy);

endmodule

// File: rtl/i2c_alm_seq.sv
module i2c_alm_seq
  import i2c_alm_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              go,
  input  logic              release_hold,
  input  logic              scl_i,
  input  logic [ADDR_W-1:0] addr_byte,
  output logic              scl_low,
  output logic              sda_low,
  output logic              active,
  output logic              in_hold,
  output logic              done
);
  localparam int NCLK = ADDR_W + 1;
  localparam int TW   = $clog2(HALF_CYC + 1);
  localparam int BW   = $clog2(NCLK + 1);

  ms_state_t         st;
  logic [TW-1:0]     tmr;
  logic [BW-1:0]     bitn;
  logic [ADDR_W-1:0] shreg;
  logic              tmr_end, data_bit;

  assign tmr_end  = (tmr == TW'(HALF_CYC - 1));
  assign data_bit = (bitn < BW'(ADDR_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= MS_IDLE;
      tmr   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else if (!en) begin
      st  <= MS_IDLE;
      tmr <= '0;
    end else begin
      case (st)
        MS_IDLE: if (go) begin
          st <= MS_START; tmr <= '0; bitn <= '0; shreg <= addr_byte;
        end
        MS_START: if (tmr_end) begin st <= MS_LOW; tmr <= '0; end
                  else tmr <= tmr + 1'b1;
        MS_LOW:   if (tmr_end) begin st <= MS_HIGH; tmr <= '0; end
                  else tmr <= tmr + 1'b1;
        MS_HIGH: if (scl_i) begin
          if (tmr_end) begin
            tmr <= '0;
            if (bitn == BW'(NCLK - 1)) st <= MS_HOLD;
            else begin
              bitn  <= bitn + 1'b1;
              shreg <= {shreg[ADDR_W-2:0], 1'b0};
              st    <= MS_LOW;
            end
          end else tmr <= tmr + 1'b1;
        end
        MS_HOLD: if (release_hold) begin st <= MS_STOP_LO; tmr <= '0; end
        MS_STOP_LO: if (tmr_end) begin st <= MS_STOP_HI; tmr <= '0; end
                    else tmr <= tmr + 1'b1;
        MS_STOP_HI: if (scl_i) begin
          if (tmr_end) begin st <= MS_IDLE; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        end
        default: st <= MS_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (st)
      MS_START:         sda_low = 1'b1;
      MS_LOW:   begin   scl_low = 1'b1; sda_low = data_bit & ~shreg[ADDR_W-1]; end
      MS_HIGH:          sda_low = data_bit & ~shreg[ADDR_W-1];
      MS_HOLD:          scl_low = 1'b1;
      MS_STOP_LO: begin scl_low = 1'b1; sda_low = 1'b1; end
      MS_STOP_HI:       sda_low = 1'b1;
      default: ;
    endcase
  end

  assign active  = (st != MS_IDLE);
  assign in_hold = (st == MS_HOLD);
  assign done    = (st == MS_STOP_HI) & scl_i & tmr_end;

  assert_ack_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MS_HIGH && bitn == BW'(NCLK - 1)) |-> !sda_low);

endmodule

// File: rtl/i2c_alm_regs.sv
module i2c_alm_regs
  import i2c_alm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  input  logic              bus_busy,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              ninth_fall,
  input  logic              seq_active,
  input  logic              seq_hold,
  input  logic              seq_done,
  output logic              en,
  output logic              go,
  output logic              release_hold,
  output logic [DATA_W-1:0] addr_byte,
  output logic              evt,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data
);
  logic en_q, lie_q, mst_q, lost_q, lost_pend, evt_q, from_loss_q;
  logic [DATA_W-1:0] addr_q;
  logic wr_ctrl, wr_stat, wr_addr, req, lose_now, clr_lost, clr_evt, set_evt;

  assign wr_ctrl  = wr_en & (wr_sel == SEL_CTRL);
  assign wr_stat  = wr_en & (wr_sel == SEL_STAT);
  assign wr_addr  = wr_en & (wr_sel == SEL_ADDR);
  assign req      = wr_ctrl & wr_data[CTRL_MST] & wr_data[CTRL_EN] & en_q & ~mst_q & ~seq_active;
  assign lose_now = req & request_lost(bus_busy, start_det);
  assign go       = req & ~lose_now;
  assign clr_lost = wr_stat & ~wr_data[STAT_LOST];
  assign clr_evt  = wr_stat & ~wr_data[STAT_EVT];
  assign set_evt  = ninth_fall & (lost_pend | seq_hold);
  assign release_hold = evt_q & clr_evt & ~set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; lie_q <= 1'b0; addr_q <= '0;
      mst_q <= 1'b0; lost_q <= 1'b0; lost_pend <= 1'b0;
      evt_q <= 1'b0; from_loss_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wr_data[CTRL_EN];
        lie_q <= wr_data[CTRL_LIE];
      end
      if (wr_addr) addr_q <= wr_data;
      if (!en_q) begin
        mst_q <= 1'b0; lost_q <= 1'b0; lost_pend <= 1'b0;
        evt_q <= 1'b0; from_loss_q <= 1'b0;
      end else begin
        if (go)            mst_q <= 1'b1;
        else if (seq_done) mst_q <= 1'b0;
        if (lose_now)      lost_q <= 1'b1;
        else if (clr_lost) lost_q <= 1'b0;
        if (lose_now)                 lost_pend <= 1'b1;
        else if (set_evt || stop_det) lost_pend <= 1'b0;
        if (set_evt) begin
          evt_q <= 1'b1; from_loss_q <= lost_pend;
        end else if (clr_evt) begin
          evt_q <= 1'b0; from_loss_q <= 1'b0;
        end
      end
    end
  end

  assign en        = en_q;
  assign addr_byte = addr_q;
  assign evt       = evt_q;
  assign irq       = irq_level(evt_q, from_loss_q, lost_q, lie_q);

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CTRL: begin
        rd_data[CTRL_EN]  = en_q;
        rd_data[CTRL_MST] = mst_q;
        rd_data[CTRL_LIE] = lie_q;
      end
      SEL_STAT: begin
        rd_data[STAT_LOST] = lost_q;
        rd_data[STAT_EVT]  = evt_q;
        rd_data[STAT_BUSY] = bus_busy;
      end
      SEL_ADDR: rd_data = addr_q;
      default: ;
    endcase
  end

  assert_lost_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lose_now |=> (lost_q && !mst_q));
  assert_event_after_ninth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(ninth_fall));
  assert_irq_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt_q);
  assert_lost_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lost && !lose_now && en_q) |=> !lost_q);
  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!lost_q && !evt_q && !mst_q));

endmodule

// File: rtl/i2c_al_master.sv
module i2c_al_master
  import i2c_alm_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq
);
  localparam int CLKS_PER_XFER = DATA_W + 1;

  logic en, go, release_hold, evt;
  logic start_det, stop_det, ninth_fall, busy;
  logic seq_scl_low, seq_sda_low, seq_active, seq_hold, seq_done;
  logic [DATA_W-1:0] addr_byte;

  i2c_alm_busmon #(.CLKS_PER_XFER(CLKS_PER_XFER)) u_mon (
    .clk(clk), .rst_n(rst_n), .en(en), .scl_i(scl_i), .sda_i(sda_i),
    .start_det(start_det), .stop_det(stop_det), .ninth_fall(ninth_fall), .busy(busy)
  );

  i2c_alm_seq #(.HALF_CYC(HALF_CYC), .ADDR_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .go(go), .release_hold(release_hold),
    .scl_i(scl_i), .addr_byte(addr_byte),
    .scl_low(seq_scl_low), .sda_low(seq_sda_low), .active(seq_active),
    .in_hold(seq_hold), .done(seq_done)
  );

  i2c_alm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .bus_busy(busy), .start_det(start_det), .stop_det(stop_det),
    .ninth_fall(ninth_fall), .seq_active(seq_active), .seq_hold(seq_hold),
    .seq_done(seq_done), .en(en), .go(go), .release_hold(release_hold),
    .addr_byte(addr_byte), .evt(evt), .irq(irq), .rd_data(rd_data)
  );

  // The event flag alone is enough to stretch the clock line
  assign scl_oe = seq_scl_low | evt;
  assign sda_oe = seq_sda_low;

  assert_scl_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && $past(evt)) |-> !scl_i);

endmodule

// File: tb/tb_i2c_al_master.sv
module tb_i2c_al_master;
  localparam int CLK_PERIOD = 10;
  localparam int FH = 6;
  // {pre_busy, lie, exp_lost, exp_mst}
  localparam logic [3:0] VEC [4] = '{4'b0001, 4'b0101, 4'b1010, 4'b1110};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic scl_oe, sda_oe, irq;
  logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
  wire scl_w = ~(scl_oe | tb_scl_low);
  wire sda_w = ~(sda_oe | tb_sda_low);
  int checks = 0, errors = 0;
  logic [7:0] v8;
  logic [3:0] vec;

  i2c_al_master dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); rd_sel = s; #1 d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic f_start();
    @(negedge clk); tb_sda_low = 1'b1; idle(FH);
  endtask

  task automatic f_bit(input logic b);
    @(negedge clk); tb_scl_low = 1'b1; tb_sda_low = ~b; idle(FH);
    tb_scl_low = 1'b0;
    while (!scl_w) @(negedge clk);
    idle(FH);
  endtask

  task automatic f_stop();
    @(negedge clk); tb_scl_low = 1'b1; tb_sda_low = 1'b1; idle(FH);
    tb_scl_low = 1'b0;
    while (!scl_w) @(negedge clk);
    idle(FH); tb_sda_low = 1'b0; idle(FH);
  endtask

  task automatic own_xfer(input logic [7:0] a);
    logic [7:0] got;
    wr(2'd2, a);
    wr(2'd0, 8'h03);
    #1 chk("R3 start sda low", {6'd0, scl_w, sda_w}, 8'h02);
    rd(2'd0, v8); chk("R3 master mode", v8[1], 1'b1);
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_w); #1 got[7-i] = sda_w;
    end
    chk("R4 address bits", got, a);
    @(negedge scl_w); @(negedge clk); tb_sda_low = 1'b1;
    @(posedge scl_w); #1 chk("R4 sda released ninth", sda_oe, 1'b0);
    rd(2'd1, v8); chk("R6 no event before ninth fall", v8[1], 1'b0);
    @(negedge scl_w); idle(3); tb_sda_low = 1'b0;
    rd(2'd1, v8); chk("R6 event own", v8[1:0], 2'b10);
    chk("R8 irq own", irq, 1'b1);
    idle(20); chk("R7 scl held", scl_w, 1'b0);
    wr(2'd1, 8'h00);
    idle(30);
    rd(2'd1, v8); chk("R7 stop after release", v8[2:0], 3'b000);
    rd(2'd0, v8); chk("R7 master dropped", v8[1], 1'b0);
    chk("R7 lines released", {6'd0, scl_w, sda_w}, 8'h03);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    // R1 reset state
    rd(2'd0, v8); chk("R1 ctrl", v8, 8'h00);
    rd(2'd1, v8); chk("R1 stat", v8, 8'h00);
    rd(2'd2, v8); chk("R1 addr", v8, 8'h00);
    chk("R1 outputs", {5'd0, scl_oe, sda_oe, irq}, 8'h00);

    // Table: request with and without a busy bus
    for (int k = 0; k < 4; k++) begin
      vec = VEC[k];
      wr(2'd0, {5'd0, vec[2], 2'b01});
      if (vec[3]) f_start();
      wr(2'd0, {5'd0, vec[2], 2'b11});
      rd(2'd1, v8); chk("R5 table lost flag", v8[0], vec[1]);
      rd(2'd0, v8); chk("R5 table master", v8[1], vec[0]);
      chk("R8 table no early irq", irq, 1'b0);
      if (vec[1]) chk("R5 table sda untouched", sda_oe, 1'b0);
      wr(2'd0, 8'h00);
      tb_sda_low = 1'b0; tb_scl_low = 1'b0; idle(6);
    end

    // R9: writing ones to flags has no effect
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h07);
    rd(2'd1, v8); chk("R9 write ones ignored", v8, 8'h00);

    // R2 busy tracking with a foreign master
    f_start();
    rd(2'd1, v8); chk("R2 busy on start", v8[2], 1'b1);
    f_stop();
    rd(2'd1, v8); chk("R2 idle on stop", v8[2], 1'b0);

    // R3 R4 R6 R7 R8 own transfers, two patterns
    own_xfer(8'hA5);
    own_xfer(8'h3C);

    // R5 R6 R7 R8 R9 lost transfer with interrupt enabled
    wr(2'd0, 8'h05);
    f_start();
    wr(2'd0, 8'h07);
    rd(2'd1, v8); chk("R5 lost set", v8[0], 1'b1);
    rd(2'd0, v8); chk("R5 master off", v8[1], 1'b0);
    for (int i = 0; i < 9; i++) begin
      f_bit(i[0]);
      chk("R5 sda not driven", sda_oe, 1'b0);
    end
    rd(2'd1, v8); chk("R6 no event before fall", v8[1], 1'b0);
    chk("R8 no irq before ninth", irq, 1'b0);
    @(negedge clk); tb_scl_low = 1'b1; idle(3);
    rd(2'd1, v8); chk("R6 event lost", v8[1:0], 2'b11);
    chk("R8 irq lost enabled", irq, 1'b1);
    tb_scl_low = 1'b0; idle(5);
    chk("R7 scl held lost", scl_w, 1'b0);
    wr(2'd1, 8'h02);
    rd(2'd1, v8); chk("R9 lost cleared event kept", v8[1:0], 2'b10);
    chk("R9 irq dropped", irq, 1'b0);
    chk("R9 scl still held", scl_w, 1'b0);
    wr(2'd1, 8'h00); idle(2);
    chk("R7 scl released", scl_w, 1'b1);
    f_stop();
    rd(2'd1, v8); chk("R2 idle after foreign stop", v8, 8'h00);

    // R8 R10 lost transfer with interrupt disabled, then R11
    wr(2'd0, 8'h01);
    f_start();
    wr(2'd0, 8'h03);
    for (int i = 0; i < 9; i++) f_bit(1'b1);
    @(negedge clk); tb_scl_low = 1'b1; idle(3);
    rd(2'd1, v8); chk("R8 event without enable", v8[1], 1'b1);
    chk("R8 irq gated off", irq, 1'b0);
    wr(2'd0, 8'h05); chk("R10 irq enabled", irq, 1'b1);
    wr(2'd0, 8'h01); chk("R10 irq stopped", irq, 1'b0);
    tb_scl_low = 1'b0;
    wr(2'd0, 8'h00); idle(2);
    rd(2'd1, v8); chk("R11 flags cleared", v8, 8'h00);
    chk("R11 lines and irq", {5'd0, scl_oe, sda_oe, irq}, 8'h00);
    tb_sda_low = 1'b0; idle(4);

    // R5 same-cycle request and foreign START
    wr(2'd0, 8'h01);
    @(negedge clk); tb_sda_low = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h03;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd1, v8); chk("R5 same-cycle lost and busy", v8[2:0], 3'b101);
    rd(2'd0, v8); chk("R5 same-cycle master off", v8[1], 1'b0);
    chk("R5 same-cycle sda", sda_oe, 1'b0);
    wr(2'd0, 8'h00); tb_sda_low = 1'b0; idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule